// File: doc/BRIEF.md
# Serial Receiver with Sticky Error Flags

This block recovers bytes from an asynchronous serial line that rests high. It runs on the system clock and takes a separate enable pulse at sixteen times the bit rate. A high-to-low edge on the line starts a search for a start bit. The start bit is accepted only if the line is still low half a bit later. Each following bit is then sampled at its centre. The byte goes into a holding register, and a ready flag tells the consumer that a byte is waiting.

A frame is built as follows, in line order:
- a start bit at 0;
- eight data bits, least significant first;
- an optional parity bit;
- a stop bit, which should be 1.

The parity setting chooses even, odd, forced-zero, forced-one or no parity. A wrong parity bit or a stop bit read as 0 raises an error flag. The error flag appears in the same cycle as the ready flag. Error flags stay set across later bytes until the consumer pulses the status-clear input. Reading the byte clears only the ready flag. A byte that arrives before the previous one is read replaces it.

Top module: `serial_rx_sticky`

## Requirements
- R1: After reset `ready_o`, `par_err_o` and `frame_err_o` are 0 and `data_o` is 0x00.
- R2: A frame is one start bit at 0, eight data bits sent least significant bit first, an optional parity bit and one stop bit. When the stop bit has been sampled, `data_o` holds the eight data bits with bit 0 taken from the first data bit, and `ready_o` goes to 1.
- R3: If the stop bit is sampled as 0, `frame_err_o` goes to 1 in the same cycle that `ready_o` goes to 1.
- R4: Once set, `frame_err_o` stays 1 while further correct frames are received. It returns to 0 only after a one-cycle pulse on `clr_sts_i`.
- R5: `par_mode_i` takes these values:
  - 0 = even: the data bits and the parity bit together hold an even number of ones.
  - 1 = odd: the data bits and the parity bit together hold an odd number of ones.
  - 2 = the parity bit must be 0.
  - 3 = the parity bit must be 1.

  A parity bit that breaks the selected rule sets `par_err_o` in the same cycle that `ready_o` is set.
- R6: With `par_mode_i` at 4 to 7 there is no parity bit, and the stop bit directly follows the eighth data bit. `par_err_o` is never set in this mode. The mode is captured when a start bit is detected.
- R7: If the line returns high before the middle of the start bit, the low pulse is a glitch. It produces no byte, `ready_o` stays 0, and the next proper frame is received normally.
- R8: A one-cycle pulse on `rd_i` clears `ready_o` and leaves `data_o` unchanged.
- R9: If `clr_sts_i` is pulsed in the same cycle that a new error is detected, the error flag ends up set.
- R10: A byte that completes while `ready_o` is still 1 replaces `data_o`, and `ready_o` stays 1.
- R11: `par_err_o` stays 1 while further correct frames are received. It clears only on a `clr_sts_i` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_i | input | 1 | Serial input line, idle high |
| tick_i | input | 1 | One-cycle enable pulse at 16x the bit rate |
| par_mode_i | input | 3 | Parity setting (0 even, 1 odd, 2 forced 0, 3 forced 1, 4-7 none) |
| rd_i | input | 1 | Read pulse; clears the ready flag |
| clr_sts_i | input | 1 | Status-clear pulse; clears the sticky error flags |
| data_o | output | 8 | Last received byte |
| ready_o | output | 1 | A received byte is waiting |
| par_err_o | output | 1 | Sticky parity error flag |
| frame_err_o | output | 1 | Sticky framing error flag |

## Verification
The bench covers the following cases, each aimed at a specific design fault:
- A short low pulse on the line. A design without mid-bit start confirmation would report a spurious byte, or lose alignment for the frame that follows.
- Correct frames sent after an error frame. A design that clears its error flags per character would drop the error at that point.
- A status-clear pulse timed to the exact cycle a new framing error lands. A design that gives the clear priority would lose that error.
- Each parity setting in turn, plus bytes with distinct bit patterns and an unread byte followed by a second byte. These expose:
  - reversed bit order;
  - swapped parity polarity;
  - a receiver that expects a parity bit when parity is off;
  - a holding register that refuses to be overwritten.

// File: rtl/srx_pkg.sv
package srx_pkg;
  typedef enum logic [2:0] {
    PAR_EVEN  = 3'd0,
    PAR_ODD   = 3'd1,
    PAR_SPACE = 3'd2,
    PAR_MARK  = 3'd3,
    PAR_NONE  = 3'd4
  } par_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;

  function automatic logic par_enabled(input logic [2:0] mode);
    return (mode < 3'd4);
  endfunction

  function automatic logic par_good(input logic [2:0] mode, input logic ones_odd, input logic pbit);
    case (mode)
      3'd0:    return (ones_odd ^ pbit) == 1'b0;
      3'd1:    return (ones_odd ^ pbit) == 1'b1;
      3'd2:    return pbit == 1'b0;
      3'd3:    return pbit == 1'b1;
      default: return 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) chain_q[0] <= 1'b1;
          else         chain_q[0] <= d_i;
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) chain_q[g] <= 1'b1;
          else         chain_q[g] <= chain_q[g-1];
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/srx_frame.sv
module srx_frame
  import srx_pkg::*;
#(
  parameter int OVS    = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              line_i,
  input  logic [2:0]        par_mode_i,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic              par_bad_o,
  output logic              stop_bad_o
);
  localparam int CNT_W = $clog2(OVS);
  localparam int BIT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] HALF_M1 = CNT_W'(OVS/2 - 1);
  localparam logic [CNT_W-1:0] LAST    = CNT_W'(OVS - 1);
  localparam logic [BIT_W-1:0] BIT_END = BIT_W'(DATA_W - 1);

  rx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BIT_W-1:0]  bit_q;
  logic [DATA_W-1:0] shift_q;
  logic [2:0]        mode_q;
  logic              pbit_q;
  logic              done_q, par_bad_q, stop_bad_q;
  logic              at_centre;

  assign at_centre = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      bit_q      <= '0;
      shift_q    <= '0;
      mode_q     <= 3'(PAR_NONE);
      pbit_q     <= 1'b0;
      done_q     <= 1'b0;
      par_bad_q  <= 1'b0;
      stop_bad_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (tick_i) begin
        case (state_q)
          ST_IDLE: if (!line_i) begin
            state_q <= ST_START;
            cnt_q   <= '0;
            mode_q  <= par_mode_i;  // mode held for the whole frame
          end
          ST_START: begin
            if (cnt_q == HALF_M1) begin
              cnt_q   <= '0;
              bit_q   <= '0;
              state_q <= line_i ? ST_IDLE : ST_DATA;  // glitch rejection
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_DATA: begin
            if (at_centre) begin
              cnt_q   <= '0;
              shift_q <= {line_i, shift_q[DATA_W-1:1]};
              bit_q   <= bit_q + 1'b1;
              if (bit_q == BIT_END)
                state_q <= par_enabled(mode_q) ? ST_PAR : ST_STOP;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_PAR: begin
            if (at_centre) begin
              cnt_q   <= '0;
              pbit_q  <= line_i;
              state_q <= ST_STOP;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_STOP: begin
            if (at_centre) begin
              cnt_q      <= '0;
              done_q     <= 1'b1;
              stop_bad_q <= !line_i;
              par_bad_q  <= par_enabled(mode_q) && !par_good(mode_q, ^shift_q, pbit_q);
              state_q    <= ST_IDLE;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign done_o     = done_q;
  assign data_o     = shift_q;
  assign par_bad_o  = par_bad_q;
  assign stop_bad_o = stop_bad_q;
endmodule

// File: rtl/srx_status.sv
module srx_status #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              par_bad_i,
  input  logic              stop_bad_i,
  input  logic              rd_i,
  input  logic              clr_i,
  output logic [DATA_W-1:0] data_o,
  output logic              ready_o,
  output logic              par_err_o,
  output logic              frame_err_o
);
  logic [DATA_W-1:0] data_q;
  logic              ready_q, par_q, frame_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      ready_q <= 1'b0;
      par_q   <= 1'b0;
      frame_q <= 1'b0;
    end else begin
      if (done_i) data_q <= data_i;
      if (done_i)    ready_q <= 1'b1;
      else if (rd_i) ready_q <= 1'b0;
      // new error wins over a simultaneous clear
      par_q   <= (done_i && par_bad_i)  || (par_q   && !clr_i);
      frame_q <= (done_i && stop_bad_i) || (frame_q && !clr_i);
    end
  end

  assign data_o      = data_q;
  assign ready_o     = ready_q;
  assign par_err_o   = par_q;
  assign frame_err_o = frame_q;
endmodule

// File: rtl/serial_rx_sticky.sv
module serial_rx_sticky #(
  parameter int OVS         = 16,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_i,
  input  logic              tick_i,
  input  logic [2:0]        par_mode_i,
  input  logic              rd_i,
  input  logic              clr_sts_i,
  output logic [DATA_W-1:0] data_o,
  output logic              ready_o,
  output logic              par_err_o,
  output logic              frame_err_o
);
  logic              line_s;
  logic              done_w, par_bad_w, stop_bad_w;
  logic [DATA_W-1:0] shift_w;

  srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (line_i),
    .q_o   (line_s)
  );

  srx_frame #(.OVS(OVS), .DATA_W(DATA_W)) u_frame (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .line_i    (line_s),
    .par_mode_i(par_mode_i),
    .done_o    (done_w),
    .data_o    (shift_w),
    .par_bad_o (par_bad_w),
    .stop_bad_o(stop_bad_w)
  );

  srx_status #(.DATA_W(DATA_W)) u_status (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .done_i     (done_w),
    .data_i     (shift_w),
    .par_bad_i  (par_bad_w),
    .stop_bad_i (stop_bad_w),
    .rd_i       (rd_i),
    .clr_i      (clr_sts_i),
    .data_o     (data_o),
    .ready_o    (ready_o),
    .par_err_o  (par_err_o),
    .frame_err_o(frame_err_o)
  );
endmodule

// File: rtl/serial_rx_sticky_chk.sv
module serial_rx_sticky_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_i,
  input logic              clr_sts_i,
  input logic [DATA_W-1:0] data_o,
  input logic              ready_o,
  input logic              par_err_o,
  input logic              frame_err_o,
  input logic              done_w,
  input logic              par_bad_w,
  input logic              stop_bad_w
);
  AST_READY_AFTER_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_w |=> ready_o);  // R2
  AST_DATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_w |=> $stable(data_o));  // R8
  AST_FRAME_WITH_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(frame_err_o) |-> ready_o && $past(done_w));  // R3
  AST_FRAME_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_err_o && !clr_sts_i |=> frame_err_o);  // R4
  AST_PAR_WITH_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(par_err_o) |-> ready_o && $past(done_w));  // R5
  AST_PAR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    par_err_o && !clr_sts_i |=> par_err_o);  // R11
  AST_READ_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && !done_w |=> !ready_o);  // R8
  AST_ERR_BEATS_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_w && (stop_bad_w || par_bad_w) && clr_sts_i |=> frame_err_o || par_err_o);  // R9
endmodule

bind serial_rx_sticky serial_rx_sticky_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rd_i       (rd_i),
  .clr_sts_i  (clr_sts_i),
  .data_o     (data_o),
  .ready_o    (ready_o),
  .par_err_o  (par_err_o),
  .frame_err_o(frame_err_o),
  .done_w     (done_w),
  .par_bad_w  (par_bad_w),
  .stop_bad_w (stop_bad_w)
);

// File: tb/serial_rx_sticky_bench.sv
module serial_rx_sticky_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam int BIT_CLK    = 16 * TICK_DIV;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       line_i = 1'b1;
  logic       tick_i = 1'b0;
  logic [2:0] par_mode_i = 3'd4;
  logic       rd_i = 1'b0;
  logic       clr_sts_i = 1'b0;
  logic [7:0] data_o;
  logic       ready_o, par_err_o, frame_err_o;
  int         n_checks = 0;
  int         n_err = 0;
  int         div = 0;

  serial_rx_sticky u_serial_rx_sticky (
    .clk_i(clk_i), .rst_ni(rst_ni), .line_i(line_i), .tick_i(tick_i),
    .par_mode_i(par_mode_i), .rd_i(rd_i), .clr_sts_i(clr_sts_i),
    .data_o(data_o), .ready_o(ready_o), .par_err_o(par_err_o),
    .frame_err_o(frame_err_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  always @(negedge clk_i) begin
    div    = (div == TICK_DIV-1) ? 0 : div + 1;
    tick_i = (div == 0);
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic pbit_for(input logic [2:0] mode, input logic [7:0] d);
    case (mode)
      3'd0:    return ^d;
      3'd1:    return ~^d;
      3'd2:    return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  task automatic hold_bit(input logic v);
    line_i = v;
    repeat (BIT_CLK) @(negedge clk_i);
  endtask

  task automatic send(input logic [7:0] d, input logic has_par, input logic pbit,
                      input logic stop, input logic clr_on_done);
    hold_bit(1'b0);
    for (int i = 0; i < 8; i++) hold_bit(d[i]);
    if (has_par) hold_bit(pbit);
    line_i = stop;
    for (int k = 0; k < BIT_CLK; k++) begin
      clr_sts_i = clr_on_done && !ready_o;
      @(negedge clk_i);
    end
    clr_sts_i = 1'b0;
    hold_bit(1'b1);
  endtask

  task automatic pulse_rd();
    rd_i = 1'b1; @(negedge clk_i); rd_i = 1'b0; @(negedge clk_i);
  endtask

  task automatic pulse_clr();
    clr_sts_i = 1'b1; @(negedge clk_i); clr_sts_i = 1'b0; @(negedge clk_i);
  endtask

  task automatic t_reset();
    chk("R1 ready", ready_o, 0);
    chk("R1 par_err", par_err_o, 0);
    chk("R1 frame_err", frame_err_o, 0);
    chk("R1 data", data_o, 8'h00);
  endtask

  task automatic t_basic();
    par_mode_i = 3'd4;
    send(8'hA5, 1'b0, 1'b0, 1'b1, 1'b0);
    chk("R2 data", data_o, 8'hA5);
    chk("R2 ready", ready_o, 1);
    chk("R6 no par_err", par_err_o, 0);
    chk("R2 no frame_err", frame_err_o, 0);
    pulse_rd();
    chk("R8 ready cleared", ready_o, 0);
    chk("R8 data kept", data_o, 8'hA5);
    par_mode_i = 3'd7;
    send(8'h01, 1'b0, 1'b0, 1'b1, 1'b0);
    chk("R6 mode7 data", data_o, 8'h01);
    chk("R6 mode7 par_err", par_err_o, 0);
    pulse_rd();
  endtask

  task automatic t_parity();
    logic [7:0] pats [4] = '{8'h3C, 8'h01, 8'hC8, 8'h7F};
    for (int m = 0; m < 4; m++) begin
      par_mode_i = 3'(m);
      send(pats[m], 1'b1, pbit_for(3'(m), pats[m]), 1'b1, 1'b0);
      chk("R5 good parity data", data_o, pats[m]);
      chk("R5 good parity flag", par_err_o, 0);
      pulse_rd();
    end
    par_mode_i = 3'd0;
    send(8'h07, 1'b1, ~pbit_for(3'd0, 8'h07), 1'b1, 1'b0);
    chk("R5 bad even parity", par_err_o, 1);
    chk("R5 ready with error", ready_o, 1);
    pulse_rd();
    par_mode_i = 3'd4;
    send(8'h55, 1'b0, 1'b0, 1'b1, 1'b0);
    chk("R11 par_err sticky", par_err_o, 1);
    chk("R11 data after error", data_o, 8'h55);
    pulse_clr();
    chk("R11 par_err cleared", par_err_o, 0);
    pulse_rd();
    par_mode_i = 3'd3;
    send(8'h10, 1'b1, 1'b0, 1'b1, 1'b0);
    chk("R5 mark mismatch", par_err_o, 1);
    pulse_clr();
    pulse_rd();
  endtask

  task automatic t_frame();
    par_mode_i = 3'd4;
    send(8'h96, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R3 frame_err", frame_err_o, 1);
    chk("R3 ready", ready_o, 1);
    chk("R3 data", data_o, 8'h96);
    pulse_rd();
    send(8'h42, 1'b0, 1'b0, 1'b1, 1'b0);
    chk("R4 frame_err sticky", frame_err_o, 1);
    chk("R4 data", data_o, 8'h42);
    pulse_clr();
    chk("R4 frame_err cleared", frame_err_o, 0);
    pulse_rd();
  endtask

  task automatic t_glitch();
    par_mode_i = 3'd4;
    line_i = 1'b0;
    repeat (3 * TICK_DIV) @(negedge clk_i);
    line_i = 1'b1;
    repeat (12 * BIT_CLK) @(negedge clk_i);
    chk("R7 no byte from glitch", ready_o, 0);
    send(8'h5A, 1'b0, 1'b0, 1'b1, 1'b0);
    chk("R7 next frame data", data_o, 8'h5A);
    chk("R7 next frame ready", ready_o, 1);
    pulse_rd();
  endtask

  task automatic t_overwrite();
    par_mode_i = 3'd4;
    send(8'h11, 1'b0, 1'b0, 1'b1, 1'b0);
    send(8'h22, 1'b0, 1'b0, 1'b1, 1'b0);
    chk("R10 overwritten data", data_o, 8'h22);
    chk("R10 ready held", ready_o, 1);
    pulse_rd();
  endtask

  task automatic t_collide();
    par_mode_i = 3'd4;
    send(8'hE1, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R9 error beats clear", frame_err_o, 1);
    chk("R9 ready", ready_o, 1);
    pulse_clr();
    pulse_rd();
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    t_basic();
    t_parity();
    t_frame();
    t_glitch();
    t_overwrite();
    t_collide();
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++;
    n_err++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end
endmodule